// File: doc/BRIEF.md
# Set-Associative Translation Cache with Address-Space Tags

This block holds recently used virtual-to-physical page translations, so that most memory references skip a page-table walk. A requester presents a 20-bit virtual page number, the current 8-bit address-space identifier and a write qualifier. In the same cycle, through combinational logic only, the block reports a hit, a protection fault, the 20-bit frame number and the seven permission and status flags of the matching entry.

When a lookup misses, a walker outside the block fetches the mapping and writes it through the fill port. The fill lands on the next clock edge. It overwrites an existing entry of the same mapping if there is one, otherwise the first empty way, and otherwise the way chosen by a per-set tree pseudo-LRU. A flush input drops every entry that is not marked global, so a context switch does not have to discard shared mappings.

Top module: `tlb_asid_cache`

## Requirements
- R1: The low 4 bits of the page number pick one of 16 sets of 4 ways, and the upper 16 bits are the tag. A lookup with `lk_req` high whose tag matches a valid entry returns that entry's frame and flags in the same cycle. The flags bit order is [0] present, [1] user, [2] global, [3] writeable, [4] dirty, [5] used, [6] cacheable.
- R2: An entry with the global flag clear hits only when its stored identifier equals `lk_asid`.
- R3: An entry with the global flag set hits for any value of `lk_asid`.
- R4: A write lookup (`lk_write`=1) that matches an entry whose writeable flag is clear gives `lk_fault`=1 and `lk_hit`=0.
- R5: A write lookup that matches a writeable entry whose dirty flag is clear gives `lk_hit`=0 and `lk_fault`=0. A read lookup of the same entry hits.
- R6: A fill whose tag and identifier match a valid entry of its set overwrites that entry, and later lookups return the new frame.
- R7: `flush` clears every valid entry whose global flag is clear and keeps global entries.
- R8: When `flush` and `fill_en` are both high in one cycle, the fill is dropped.
- R9: A fill goes to the lowest-numbered invalid way of its set. If the set is full, a 3-bit tree pseudo-LRU per set chooses the victim, and both hits and fills update that tree.
- R10: After a synchronous active-low reset, no lookup hits.
- R11: With `lk_req` low, `lk_hit` and `lk_fault` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Usable translation found |
| lk_fault | output | 1 | Write to a read-only page |
| lk_pfn | output | 20 | Frame number of the matching entry, 0 if none |
| lk_flags | output | 7 | Flags of the matching entry, 0 if none |
| fill_en | input | 1 | Write a new mapping |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_asid | input | 8 | Identifier of the new mapping |
| fill_pfn | input | 20 | Frame number of the new mapping |
| fill_flags | input | 7 | Flags of the new mapping |
| flush | input | 1 | Drop all non-global entries |

## Verification
The bench fills a set, touches one of its entries, and fills again. A design that picked victims first-in-first-out, or that did not update the tree on a hit, would evict the wrong mapping. It refills a mapping that is already cached: a design that made a duplicate would still return the old frame from the lower way. It flushes a set that holds a global entry behind the tree's pointer and then fills it. A design that ignored empty ways would throw away the global mapping that the flush kept. Other cases check that a flush issued with a fill leaves the fill out, and that a clean or read-only page is never reported as a write hit.

// File: rtl/tlb_pkg.sv
// Shared constants for the translation cache: associativity and flag layout.
// Assumes exactly four ways, which the 3-bit pseudo-LRU tree requires.
package tlb_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int FLAG_W = 7;
    localparam int F_PRESENT = 0;
    localparam int F_USER    = 1;
    localparam int F_GLOBAL  = 2;
    localparam int F_WRITE   = 3;
    localparam int F_DIRTY   = 4;
    localparam int F_USED    = 5;
    localparam int F_CACHE   = 6;
endpackage

// File: rtl/tlb_way_match.sv
// Compares one set's ways against a tag and identifier. Global ways skip the
// identifier compare. Reports the per-way match vector, whether any way matched,
// and the lowest matching way. Purely combinational.
module tlb_way_match
    import tlb_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int ASID_W = 8
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0]             glob,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][ASID_W-1:0] asids,
    input  logic [TAG_W-1:0]            tag,
    input  logic [ASID_W-1:0]           asid,
    output logic [WAYS-1:0]             match,
    output logic                        any,
    output logic [WAY_W-1:0]            way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        // per-way tag and identifier compare
        assign match[g] = vld[g] && (tags[g] == tag) && (glob[g] || (asids[g] == asid));
    end

    assign any = |match;

    // lowest matching way wins
    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_plru.sv
// Per-set 3-bit tree pseudo-LRU. Bit 0 chooses the pair (0: ways 0/1,
// 1: ways 2/3), bit 1 chooses within the low pair and bit 2 within the high pair.
// Accepts one hit update and one fill update per cycle. When both touch the same
// set, the fill is applied last.
module tlb_plru
    import tlb_pkg::*;
#(
    parameter  int SETS  = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] q_set,
    output logic [WAY_W-1:0] q_way,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way
);
    logic [2:0] tree_q [SETS];
    logic [2:0] tree_d [SETS];

    function automatic logic [WAY_W-1:0] pick(input logic [2:0] t);
        if (!t[0]) return t[1] ? 2'd1 : 2'd0;
        else       return t[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
        logic [2:0] n;
        n = t;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction

    // next tree state: hit first, then fill
    always_comb begin
        tree_d = tree_q;
        if (hit_en)  tree_d[hit_set]  = touch(tree_d[hit_set], hit_way);
        if (fill_en) tree_d[fill_set] = touch(tree_d[fill_set], fill_way);
    end

    // tree state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            tree_q <= tree_d;
        end
    end

    assign q_way = pick(tree_q[q_set]);

    // R9: a way just filled is never the next victim of its set
    a_r9_fill_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (pick(tree_q[$past(fill_set)]) != $past(fill_way)));
endmodule

// File: rtl/tlb_asid_cache.sv
// Four-way set-associative translation cache with address-space tags.
// Lookup is combinational. Fill and flush act on the clock edge, and flush
// blocks a fill in the same cycle. Assumes the walker fills only after a miss,
// but handles a refill of a cached mapping by overwriting it.
module tlb_asid_cache
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [FLAG_W-1:0] lk_flags,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [FLAG_W-1:0] fill_flags,
    input  logic              flush
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic [WAYS-1:0]              vld_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
    logic [WAYS-1:0][ASID_W-1:0]  asid_q [SETS];
    logic [WAYS-1:0][PFN_W-1:0]   pfn_q  [SETS];
    logic [WAYS-1:0][FLAG_W-1:0]  flg_q  [SETS];
    logic [WAYS-1:0]              glob   [SETS];

    logic [IDX_W-1:0] l_idx, f_idx;
    logic [TAG_W-1:0] l_tag, f_tag;
    logic [WAYS-1:0]  l_match, f_match;
    logic             l_any, f_any;
    logic [WAY_W-1:0] l_way, f_way, lru_way, free_way, tgt_way;
    logic             has_free;
    logic [FLAG_W-1:0] l_flg;
    logic             fill_go;

    assign l_idx = lk_vpn[IDX_W-1:0];
    assign l_tag = lk_vpn[VPN_W-1:IDX_W];
    assign f_idx = fill_vpn[IDX_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1:IDX_W];
    assign fill_go = fill_en && !flush;

    // global flag of every entry, gathered for the matchers and flush
    always_comb begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                glob[s][w] = flg_q[s][w][F_GLOBAL];
    end

    tlb_way_match #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_lk_match (
        .vld(vld_q[l_idx]), .glob(glob[l_idx]), .tags(tag_q[l_idx]),
        .asids(asid_q[l_idx]), .tag(l_tag), .asid(lk_asid),
        .match(l_match), .any(l_any), .way(l_way)
    );

    tlb_way_match #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_fill_match (
        .vld(vld_q[f_idx]), .glob(glob[f_idx]), .tags(tag_q[f_idx]),
        .asids(asid_q[f_idx]), .tag(f_tag), .asid(fill_asid),
        .match(f_match), .any(f_any), .way(f_way)
    );

    // lookup result: write permission and dirty state qualify a match
    always_comb begin
        l_flg    = flg_q[l_idx][l_way];
        lk_fault = lk_req && l_any && lk_write && !l_flg[F_WRITE];
        lk_hit   = lk_req && l_any && !(lk_write && !(l_flg[F_WRITE] && l_flg[F_DIRTY]));
        lk_pfn   = (lk_req && l_any) ? pfn_q[l_idx][l_way] : '0;
        lk_flags = (lk_req && l_any) ? l_flg : '0;
    end

    // lowest invalid way of the fill set
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[f_idx][w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    tlb_plru #(.SETS(SETS)) u_plru (
        .clk(clk), .rst_n(rst_n), .q_set(f_idx), .q_way(lru_way),
        .hit_en(lk_hit), .hit_set(l_idx), .hit_way(l_way),
        .fill_en(fill_go), .fill_set(f_idx), .fill_way(tgt_way)
    );

    // fill target: existing mapping, then empty way, then pseudo-LRU victim
    assign tgt_way = f_any ? f_way : (has_free ? free_way : lru_way);

    // valid bits: reset, flush of non-global entries, or fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= vld_q[s] & glob[s];
        end else if (fill_en) begin
            vld_q[f_idx][tgt_way] <= 1'b1;
        end
    end

    // entry payload written on an accepted fill
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[f_idx][tgt_way]  <= f_tag;
            asid_q[f_idx][tgt_way] <= fill_asid;
            pfn_q[f_idx][tgt_way]  <= fill_pfn;
            flg_q[f_idx][tgt_way]  <= fill_flags;
        end
    end

    // R6: at most one way of a set ever matches a lookup
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l_match));

    // R4: a fault is never also a hit
    a_r4_fault_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    // R11: no result without a request
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_fault));

    // R8: a fill issued with a flush leaves no entry matching it in its set
    a_r8_flush_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_en && !fill_flags[F_GLOBAL] && !f_any) |=>
            !vld_q[$past(f_idx)][$past(tgt_way)] || $stable(tag_q[$past(f_idx)]));

    for (genvar gs = 0; gs < SETS; gs++) begin : g_flush_chk
        // R7: after a flush only global entries remain valid
        a_r7_flush_spares_global: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> ((vld_q[gs] & ~glob[gs]) == '0));
    end
endmodule

// File: tb/tlb_asid_cache_tb.sv
module tlb_asid_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_fault;
    logic [19:0] lk_pfn;
    logic [6:0]  lk_flags;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic [6:0]  fill_flags = '0;
    logic        flush = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tlb_asid_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_hit(lk_hit),
        .lk_fault(lk_fault), .lk_pfn(lk_pfn), .lk_flags(lk_flags),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_flags(fill_flags), .flush(flush)
    );

    // flags: [0]present [2]global [3]writeable [4]dirty
    localparam logic [6:0] RW_D  = 7'h19;
    localparam logic [6:0] GL_RW = 7'h1D;
    localparam logic [6:0] RO    = 7'h01;
    localparam logic [6:0] RW_C  = 7'h09;

    localparam logic [1:0] OP_LK = 2'd0, OP_FILL = 2'd1, OP_FLUSH = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic        wr;
        logic [19:0] pfn;
        logic [6:0]  flg;
        logic        hit;
        logic        flt;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{OP_FILL,  4'd1,  20'h00012, 8'h01, 1'b0, 20'hAAAAA, RW_D,  1'b0, 1'b0},
        '{OP_LK,    4'd1,  20'h00012, 8'h01, 1'b0, 20'hAAAAA, RW_D,  1'b1, 1'b0},
        '{OP_LK,    4'd2,  20'h00012, 8'h02, 1'b0, 20'h00000, 7'h00, 1'b0, 1'b0},
        '{OP_FILL,  4'd3,  20'h00023, 8'h01, 1'b0, 20'hBBBBB, GL_RW, 1'b0, 1'b0},
        '{OP_LK,    4'd3,  20'h00023, 8'h07, 1'b0, 20'hBBBBB, GL_RW, 1'b1, 1'b0},
        '{OP_LK,    4'd1,  20'h00012, 8'h01, 1'b1, 20'hAAAAA, RW_D,  1'b1, 1'b0},
        '{OP_FILL,  4'd4,  20'h00034, 8'h01, 1'b0, 20'h11111, RO,    1'b0, 1'b0},
        '{OP_LK,    4'd4,  20'h00034, 8'h01, 1'b1, 20'h11111, RO,    1'b0, 1'b1},
        '{OP_FILL,  4'd5,  20'h00045, 8'h01, 1'b0, 20'h22222, RW_C,  1'b0, 1'b0},
        '{OP_LK,    4'd5,  20'h00045, 8'h01, 1'b1, 20'h22222, RW_C,  1'b0, 1'b0},
        '{OP_LK,    4'd5,  20'h00045, 8'h01, 1'b0, 20'h22222, RW_C,  1'b1, 1'b0},
        '{OP_FILL,  4'd6,  20'h00012, 8'h01, 1'b0, 20'hCCCCC, RW_D,  1'b0, 1'b0},
        '{OP_LK,    4'd6,  20'h00012, 8'h01, 1'b0, 20'hCCCCC, RW_D,  1'b1, 1'b0},
        '{OP_FLUSH, 4'd7,  20'h00000, 8'h00, 1'b0, 20'h00000, 7'h00, 1'b0, 1'b0},
        '{OP_LK,    4'd7,  20'h00012, 8'h01, 1'b0, 20'h00000, 7'h00, 1'b0, 1'b0},
        '{OP_LK,    4'd7,  20'h00023, 8'h03, 1'b0, 20'hBBBBB, GL_RW, 1'b1, 1'b0},
        '{OP_LK,    4'd1,  20'h00112, 8'h01, 1'b0, 20'h00000, 7'h00, 1'b0, 1'b0}
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [7:0] a,
                           input logic [19:0] p, input logic [6:0] f, input logic fl);
        @(negedge clk);
        lk_req = 1'b0;
        fill_en = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_flags = f;
        flush = fl;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_req = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // drive a lookup, sample 5 ns later, leave the request up over the next edge
    task automatic do_lk(input logic [19:0] v, input logic [7:0] a, input logic w);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = v; lk_asid = a; lk_write = w;
        #5;
    endtask

    task automatic lk_expect(input logic [19:0] v, input logic [7:0] a, input logic w,
                             input logic eh, input logic [19:0] ep, input string req);
        do_lk(v, a, w);
        chk(lk_hit == eh, req, "hit", 32'(lk_hit), 32'(eh));
        if (eh) chk(lk_pfn == ep, req, "pfn", 32'(lk_pfn), 32'(ep));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lk_req = 1'b0; fill_en = 1'b0; flush = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R10: nothing hits after reset
        lk_expect(20'h00012, 8'h01, 1'b0, 1'b0, 20'h0, "R10");
        lk_expect(20'h00023, 8'h00, 1'b0, 1'b0, 20'h0, "R10");

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_FILL:  do_fill(VEC[i].vpn, VEC[i].asid, VEC[i].pfn, VEC[i].flg, 1'b0);
                OP_FLUSH: do_flush();
                default: begin
                    do_lk(VEC[i].vpn, VEC[i].asid, VEC[i].wr);
                    chk(lk_hit == VEC[i].hit, rtag(VEC[i].req), "hit", 32'(lk_hit), 32'(VEC[i].hit));
                    chk(lk_fault == VEC[i].flt, rtag(VEC[i].req), "fault", 32'(lk_fault), 32'(VEC[i].flt));
                    if (VEC[i].hit) begin
                        chk(lk_pfn == VEC[i].pfn, rtag(VEC[i].req), "pfn", 32'(lk_pfn), 32'(VEC[i].pfn));
                        chk(lk_flags == VEC[i].flg, rtag(VEC[i].req), "flags", 32'(lk_flags), 32'(VEC[i].flg));
                    end
                end
            endcase
        end

        // R11: a matching entry is silent while lk_req is low
        @(negedge clk);
        lk_req = 1'b0; lk_vpn = 20'h00023; lk_asid = 8'h01; lk_write = 1'b1;
        #5;
        chk(!lk_hit && !lk_fault, "R11", "hit|fault", 32'({lk_hit, lk_fault}), 32'h0);

        // R9: pseudo-LRU victim after touching the oldest way
        do_reset();
        do_fill(20'h00105, 8'h09, 20'h10501, RW_D, 1'b0);
        do_fill(20'h00205, 8'h09, 20'h20501, RW_D, 1'b0);
        do_fill(20'h00305, 8'h09, 20'h30501, RW_D, 1'b0);
        do_fill(20'h00405, 8'h09, 20'h40501, RW_D, 1'b0);
        lk_expect(20'h00105, 8'h09, 1'b0, 1'b1, 20'h10501, "R9");
        do_fill(20'h00505, 8'h09, 20'h50501, RW_D, 1'b0);
        lk_expect(20'h00305, 8'h09, 1'b0, 1'b0, 20'h0, "R9");
        lk_expect(20'h00105, 8'h09, 1'b0, 1'b1, 20'h10501, "R9");
        lk_expect(20'h00205, 8'h09, 1'b0, 1'b1, 20'h20501, "R9");
        lk_expect(20'h00405, 8'h09, 1'b0, 1'b1, 20'h40501, "R9");
        lk_expect(20'h00505, 8'h09, 1'b0, 1'b1, 20'h50501, "R9");

        // R9: an empty way left by a flush is used before the tree's victim
        do_reset();
        do_fill(20'h00107, 8'h02, 20'h71000, GL_RW, 1'b0);
        do_fill(20'h00207, 8'h02, 20'h72000, RW_D, 1'b0);
        do_fill(20'h00307, 8'h02, 20'h73000, RW_D, 1'b0);
        do_fill(20'h00407, 8'h02, 20'h74000, RW_D, 1'b0);
        do_flush();
        do_fill(20'h00507, 8'h02, 20'h75000, RW_D, 1'b0);
        lk_expect(20'h00107, 8'h05, 1'b0, 1'b1, 20'h71000, "R9");
        lk_expect(20'h00507, 8'h02, 1'b0, 1'b1, 20'h75000, "R9");
        lk_expect(20'h00207, 8'h02, 1'b0, 1'b0, 20'h0, "R7");

        // R8: a fill issued with a flush is dropped
        do_fill(20'h00606, 8'h02, 20'h66666, RW_D, 1'b1);
        lk_expect(20'h00606, 8'h02, 1'b0, 1'b0, 20'h0, "R8");
        // R2: global-clear entry misses under another identifier
        lk_expect(20'h00507, 8'h03, 1'b0, 1'b0, 20'h0, "R2");

        @(negedge clk);
        lk_req = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule